// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block sits on the device side of a single-data-rate SDRAM command interface and follows the power state that the clock-enable line selects. On every rising clock it samples the clock enable, the four command strobes and the address bus. It also receives a level from an external bank tracker that is high when every bank is idle. It compares the sampled clock enable with a registered copy of the previous level. From that pair, the command and the bank-idle level, it decides whether the device stays in normal operation or moves into power-down, self refresh or clock suspend.

All outputs are registered and describe the cycle sampled at the last rising edge. The outputs are the current power state and three single-cycle pulses. The first pulse flags a command that is illegal in the current state. The second flags a clock-enable history that cannot occur in the current state. The third acknowledges a legal command. A mode-register load is reported with its own pulse and the captured opcode. Illegal and invalid cycles leave the state unchanged.

Top module: `cke_power_tracker`

## Requirements
- R1: After reset, `pstate_o` is 0 (normal), every pulse output is low, and the previous clock enable counts as high. State codes are 0 normal, 1 power-down, 2 self refresh and 3 clock suspend. Each output reflects the inputs sampled at the preceding rising edge.
- R2: In normal state, all banks idle and clock enable going high to low, a refresh command moves the state to 2 and pulses `accept_o`. A refresh command is chip select, RAS and CAS low with WE high.
- R3: In normal state, all banks idle and clock enable going high to low, a NOP moves the state to 1 without `accept_o`. The same holds for a deselect. A NOP is chip select low with RAS, CAS and WE high. A deselect is chip select high.
- R4: In states 1 and 2, while clock enable stays low (previous and current low), the state holds and all other inputs are ignored: no pulse is raised.
- R5: In states 1 and 2, clock enable going low to high with a NOP or deselect returns the state to 0. Any other command in that cycle raises `illegal_o` and leaves the state unchanged.
- R6: In the cycle right after leaving power-down, any command other than NOP or deselect raises `illegal_o` with no accept. From the cycle after that, commands are accepted again.
- R7: In normal state with banks not all idle, clock enable going high to low with a command other than refresh or mode load moves the state to 3. Clock enable staying low holds state 3. Clock enable going low to high returns the state to 0.
- R8: A mode load command has all four strobes low. It is taken only with clock enable high in both cycles and all banks idle, and then pulses `accept_o` and `mode_load_o` and places the address on `mode_op_o`. With banks busy, it raises `illegal_o` and gives no load.
- R9: A clock-enable drop from high to low raises `illegal_o` with the state unchanged in two cases. The first is a refresh or mode load while banks are busy. The second is any command other than refresh, NOP or deselect while banks are idle.
- R10: `invalid_o` pulses, with the state unchanged, when the previous clock enable was high in states 1 or 2, or low in state 0.
- R11: `illegal_o`, `invalid_o` and `accept_o` are single-cycle pulses and never high together. `accept_o` pulses for every legal command other than NOP or deselect taken in normal state with clock enable high in both cycles.
- R12: In state 3, commands are ignored: no accept and no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable sampled this cycle |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Address bus, opcode for a mode load |
| banks_idle_i | input | 1 | High when every bank is idle |
| pstate_o | output | 2 | Power state code |
| illegal_o | output | 1 | Illegal command pulse |
| invalid_o | output | 1 | Impossible clock-enable history pulse |
| accept_o | output | 1 | Legal command accepted pulse |
| mode_load_o | output | 1 | Mode register load pulse |
| mode_op_o | output | ADDR_W | Opcode captured on the last mode load |

## Verification
The state code and every pulse output update at the rising edge that samples the stimulus, so each result is due exactly one edge after its inputs. The state entry into and exit from clock suspend also lands on that same edge. The driver applies one stimulus per falling edge and queues the result expected at the next rising edge. The monitor compares one queued item just after each rising edge, so no result is read a cycle early or late. The guard after a power-down exit is checked in the cycle after the exit edge, and in the cycle after that one.

// File: rtl/cke_pkg.sv
package cke_pkg;
  typedef enum logic [1:0] {
    PS_NORMAL  = 2'd0,
    PS_PWRDN   = 2'd1,
    PS_SELFREF = 2'd2,
    PS_SUSPEND = 2'd3
  } pstate_e;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_REF,
    CMD_MRS,
    CMD_OTHER
  } cmd_e;

  typedef struct packed {
    pstate_e nxt;
    logic    illegal;
    logic    invalid;
    logic    accept;
    logic    load;
    logic    guard;
  } step_t;
endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
  import cke_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni)                                 cmd_o = CMD_DESEL;
    else if ({ras_ni, cas_ni, we_ni} == 3'b111) cmd_o = CMD_NOP;
    else if ({ras_ni, cas_ni, we_ni} == 3'b001) cmd_o = CMD_REF;
    else if ({ras_ni, cas_ni, we_ni} == 3'b000) cmd_o = CMD_MRS;
    else                                       cmd_o = CMD_OTHER;
  end
endmodule

// File: rtl/cke_step_logic.sv
module cke_step_logic
  import cke_pkg::*;
(
  input  pstate_e state_i,
  input  logic    cke_prev_i,
  input  logic    cke_i,
  input  cmd_e    cmd_i,
  input  logic    banks_idle_i,
  input  logic    guard_i,
  output step_t   step_o
);
  logic nop_ok;
  assign nop_ok = (cmd_i == CMD_DESEL) || (cmd_i == CMD_NOP);

  always_comb begin
    step_o     = '0;
    step_o.nxt = state_i;
    unique case (state_i)
      PS_PWRDN, PS_SELFREF: begin
        if (cke_prev_i) step_o.invalid = 1'b1;
        else if (cke_i) begin
          if (nop_ok) begin
            step_o.nxt   = PS_NORMAL;
            step_o.guard = (state_i == PS_PWRDN);
          end else step_o.illegal = 1'b1;
        end
      end
      PS_SUSPEND: begin
        if (cke_i) step_o.nxt = PS_NORMAL;
      end
      default: begin
        if (!cke_prev_i) step_o.invalid = 1'b1;
        else if (guard_i && !nop_ok) step_o.illegal = 1'b1;
        else if (cke_i) begin
          if (cmd_i == CMD_MRS) begin
            if (banks_idle_i) begin
              step_o.accept = 1'b1;
              step_o.load   = 1'b1;
            end else step_o.illegal = 1'b1;
          end else if (!nop_ok) step_o.accept = 1'b1;
        end else if (banks_idle_i) begin
          // low-power entry only from all banks idle
          if (cmd_i == CMD_REF) begin
            step_o.nxt    = PS_SELFREF;
            step_o.accept = 1'b1;
          end else if (nop_ok) step_o.nxt = PS_PWRDN;
          else step_o.illegal = 1'b1;
        end else begin
          if (cmd_i == CMD_REF || cmd_i == CMD_MRS) step_o.illegal = 1'b1;
          else step_o.nxt = PS_SUSPEND;
        end
      end
    endcase
  end
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              banks_idle_i,
  output logic [1:0]        pstate_o,
  output logic              illegal_o,
  output logic              invalid_o,
  output logic              accept_o,
  output logic              mode_load_o,
  output logic [ADDR_W-1:0] mode_op_o
);
  pstate_e state_q;
  logic    cke_q;
  logic    guard_q;
  cmd_e    cmd;
  step_t   step;

  cke_cmd_decode u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cmd_o (cmd)
  );

  cke_step_logic u_step (
    .state_i     (state_q),
    .cke_prev_i  (cke_q),
    .cke_i       (cke_i),
    .cmd_i       (cmd),
    .banks_idle_i(banks_idle_i),
    .guard_i     (guard_q),
    .step_o      (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_NORMAL;
      cke_q       <= 1'b1;
      guard_q     <= 1'b0;
      illegal_o   <= 1'b0;
      invalid_o   <= 1'b0;
      accept_o    <= 1'b0;
      mode_load_o <= 1'b0;
      mode_op_o   <= '0;
    end else begin
      state_q     <= step.nxt;
      cke_q       <= cke_i;
      guard_q     <= step.guard;
      illegal_o   <= step.illegal;
      invalid_o   <= step.invalid;
      accept_o    <= step.accept;
      mode_load_o <= step.load;
      if (step.load) mode_op_o <= addr_i;
    end
  end

  assign pstate_o = state_q;
endmodule

// File: rtl/cke_power_tracker_chk.sv
module cke_power_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cke_i,
  input logic       cs_ni,
  input logic       ras_ni,
  input logic       cas_ni,
  input logic       we_ni,
  input logic       banks_idle_i,
  input logic [1:0] pstate_o,
  input logic       illegal_o,
  input logic       invalid_o,
  input logic       accept_o,
  input logic       mode_load_o
);
  logic nop_or_desel, is_mrs;
  assign nop_or_desel = cs_ni || ({ras_ni, cas_ni, we_ni} == 3'b111);
  assign is_mrs       = !cs_ni && ({ras_ni, cas_ni, we_ni} == 3'b000);

  p_flags_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({illegal_o, invalid_o, accept_o}));

  p_illegal_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o || invalid_o) |-> $stable(pstate_o));

  p_lowpower_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pstate_o == 2'd1 || pstate_o == 2'd2) && !cke_i) |=> $stable(pstate_o));

  p_exit_needs_nop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pstate_o == 2'd1 || pstate_o == 2'd2) && cke_i && !nop_or_desel)
    |=> (illegal_o || invalid_o));

  p_susp_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o == 2'd3 && cke_i) |=> pstate_o == 2'd0);

  p_susp_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o == 2'd0 && cke_i) ##1 (!cke_i && !banks_idle_i && nop_or_desel)
    |=> pstate_o == 2'd3);

  p_mrs_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && !banks_idle_i) |=> !mode_load_o);

  p_susp_no_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pstate_o == 2'd3) |=> !accept_o);
endmodule

bind cke_power_tracker cke_power_tracker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cke_i       (cke_i),
  .cs_ni       (cs_ni),
  .ras_ni      (ras_ni),
  .cas_ni      (cas_ni),
  .we_ni       (we_ni),
  .banks_idle_i(banks_idle_i),
  .pstate_o    (pstate_o),
  .illegal_o   (illegal_o),
  .invalid_o   (invalid_o),
  .accept_o    (accept_o),
  .mode_load_o (mode_load_o)
);

// File: tb/sim_cke_power_tracker.sv
module sim_cke_power_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int C_DESEL = 0, C_NOP = 1, C_REF = 2, C_MRS = 3, C_ACT = 4;

  typedef struct {
    logic [1:0]    st;
    logic          ill, inv, acc, ld;
    logic [AW-1:0] op;
    string         tag;
  } exp_t;

  logic clk = 0, rst_ni = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, idle = 1;
  logic [AW-1:0] addr = '0;
  logic [1:0] pstate;
  logic ill, inv, acc, ld;
  logic [AW-1:0] op;
  int total = 0, bad = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_power_tracker #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .addr_i(addr), .banks_idle_i(idle),
    .pstate_o(pstate), .illegal_o(ill), .invalid_o(inv), .accept_o(acc),
    .mode_load_o(ld), .mode_op_o(op)
  );

  task automatic step(input logic c, input int cmd, input logic bi,
                      input logic [AW-1:0] a, input logic [1:0] st,
                      input logic e_ill, input logic e_inv, input logic e_acc,
                      input logic e_ld, input string tag);
    exp_t e;
    @(negedge clk);
    cke = c; idle = bi; addr = a;
    case (cmd)
      C_DESEL: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      C_NOP:   {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      C_REF:   {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      C_MRS:   {cs_n, ras_n, cas_n, we_n} = 4'b0000;
      default: {cs_n, ras_n, cas_n, we_n} = 4'b0011;
    endcase
    e.st = st; e.ill = e_ill; e.inv = e_inv; e.acc = e_acc; e.ld = e_ld;
    e.op = a; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: result due one edge after the stimulus
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (pstate !== e.st || ill !== e.ill || inv !== e.inv || acc !== e.acc ||
          ld !== e.ld || (e.ld && op !== e.op)) begin
        bad++;
        $display("FAIL %s: got st=%0d ill=%b inv=%b acc=%b ld=%b op=%h exp st=%0d ill=%b inv=%b acc=%b ld=%b op=%h",
                 e.tag, pstate, ill, inv, acc, ld, op,
                 e.st, e.ill, e.inv, e.acc, e.ld, e.op);
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (pstate !== 2'd0 || ill !== 1'b0 || inv !== 1'b0 || acc !== 1'b0 || ld !== 1'b0) begin
      bad++;
      $display("FAIL R1: reset st=%0d ill=%b inv=%b acc=%b ld=%b exp 0 0 0 0 0",
               pstate, ill, inv, acc, ld);
    end
    rst_ni = 1;
    //   cke cmd   idle addr    st ill inv acc ld
    step(1, C_NOP,   1, 14'h0,  0, 0, 0, 0, 0, "R1");
    step(1, C_ACT,   1, 14'h0,  0, 0, 0, 1, 0, "R11");
    step(1, C_MRS,   1, 14'h123,0, 0, 0, 1, 1, "R8");
    step(1, C_MRS,   0, 14'h3c, 0, 1, 0, 0, 0, "R8");
    step(0, C_REF,   1, 14'h0,  2, 0, 0, 1, 0, "R2");
    step(0, C_ACT,   0, 14'h0,  2, 0, 0, 0, 0, "R4");
    step(1, C_ACT,   1, 14'h0,  2, 1, 0, 0, 0, "R5");
    step(1, C_NOP,   1, 14'h0,  2, 0, 1, 0, 0, "R10");
    step(0, C_NOP,   1, 14'h0,  2, 0, 1, 0, 0, "R10");
    step(0, C_MRS,   1, 14'h7,  2, 0, 0, 0, 0, "R4");
    step(1, C_DESEL, 1, 14'h0,  0, 0, 0, 0, 0, "R5");
    step(1, C_ACT,   1, 14'h0,  0, 0, 0, 1, 0, "R11");
    step(0, C_NOP,   1, 14'h0,  1, 0, 0, 0, 0, "R3");
    step(0, C_REF,   1, 14'h0,  1, 0, 0, 0, 0, "R4");
    step(1, C_NOP,   1, 14'h0,  0, 0, 0, 0, 0, "R5");
    step(1, C_ACT,   1, 14'h0,  0, 1, 0, 0, 0, "R6");
    step(1, C_ACT,   1, 14'h0,  0, 0, 0, 1, 0, "R6");
    step(0, C_DESEL, 1, 14'h0,  1, 0, 0, 0, 0, "R3");
    step(1, C_NOP,   1, 14'h0,  0, 0, 0, 0, 0, "R5");
    step(1, C_NOP,   1, 14'h0,  0, 0, 0, 0, 0, "R6");
    step(1, C_MRS,   1, 14'h2a5,0, 0, 0, 1, 1, "R8");
    step(0, C_NOP,   0, 14'h0,  3, 0, 0, 0, 0, "R7");
    step(0, C_ACT,   0, 14'h0,  3, 0, 0, 0, 0, "R12");
    step(0, C_MRS,   1, 14'h11, 3, 0, 0, 0, 0, "R12");
    step(1, C_ACT,   0, 14'h0,  0, 0, 0, 0, 0, "R7");
    step(1, C_NOP,   0, 14'h0,  0, 0, 0, 0, 0, "R11");
    step(0, C_REF,   0, 14'h0,  0, 1, 0, 0, 0, "R9");
    step(0, C_NOP,   0, 14'h0,  0, 0, 1, 0, 0, "R10");
    step(1, C_NOP,   1, 14'h0,  0, 0, 1, 0, 0, "R10");
    step(1, C_NOP,   1, 14'h0,  0, 0, 0, 0, 0, "R11");
    step(0, C_ACT,   1, 14'h0,  0, 1, 0, 0, 0, "R9");
    step(1, C_NOP,   1, 14'h0,  0, 0, 1, 0, 0, "R10");
    step(0, C_MRS,   0, 14'h55, 0, 1, 0, 0, 0, "R9");
    step(1, C_NOP,   0, 14'h0,  0, 0, 1, 0, 0, "R10");
    step(1, C_NOP,   1, 14'h0,  0, 0, 0, 0, 0, "R1");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule